// File: doc/BRIEF.md
# Programmable-Rate Time-of-Day Counter

This block keeps a 64-bit free-running time value for a network controller. The rate is set by one 32-bit rate word. Its upper eight bits give the number of input clock cycles in one step, and its lower 24 bits give the amount added at each step. The increment is normally scaled up as far as 24 bits allow. The low part of the count therefore holds fractions of a nanosecond, and a change of one unit in the increment trims the rate very finely. Because of that scaling the count wraps within hours, so the rollover is a plain modulo-2^64 wrap and is flagged with a one-cycle pulse.

Software reaches the counter through a small register bus with three locations: the low half of the time, the high half of the time, and the rate word. A read of the low half captures the high half at the same instant, so a later read of the high half gives a coherent 64-bit pair. A write to the low half is only held in a staging register. A write to the high half then loads the whole 64-bit value in one cycle and restarts the step prescaler. A new rate word is adopted only when the current step completes, so no increment is lost or doubled when software retunes the rate. Two setups are typical: for a 96 MHz clock, rate word 0x03FA0000 (a step of 3 cycles adding 125<<17), and for a 25 MHz clock, 0x01A00000 (a step of 1 cycle adding 40<<18).

Top module: `systime_counter`

## Requirements
- R1: After reset the time value is zero, the rate word is zero, the counter does not advance and the wrap pulse is low.
- R2: The rate word sits at bus address 2. Bits 31:24 are the step length in clock cycles and bits 23:0 are the increment. It reads back as written. Address 3 reads as zero.
- R3: After a load at clock edge L, with active step length P and increment V, the time value seen after k further edges is the loaded value plus floor(k/P)*V.
- R4: A step length of zero stops the counter. Once that word is active the time value holds until the next load.
- R5: A read of the low half (address 0) latches the high half in the same cycle. A read of address 1 returns that latched value, even if the live count has since moved on.
- R6: A write to address 0 only stages the low half and leaves the time value unchanged. A write to address 1 loads {written high half, staged low half} in one cycle.
- R7: A rate word written during a step does not take effect until that step completes. The step in progress adds the old increment with the old length.
- R8: The time value wraps modulo 2^64. In the cycle in which the wrapped value first appears, the wrap output is high for exactly one cycle.
- R9: With rate word 0x03FA0000 the count gains 16384000 every 3 cycles. With 0x01A00000 it gains 10485760 every cycle.
- R10: A load restarts the step prescaler, so the first increment after a load at edge L lands at edge L+P whatever the phase before the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that the step length counts |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of address 0 latches the high half |
| bus_addr | input | 2 | 0 time low, 1 time high (latched), 2 rate word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while bus_rd is high, else zero |
| wrap_pulse | output | 1 | High for one cycle when the count rolls past all ones |

## Verification
A wrong prescaler phase or a wrongly held rate word appears as a count that is off by one increment. This can be seen at the first read taken P cycles after a load, or at the first read after a rate change. A stale or early capture of the high half only shows when a read pair spans a carry into bit 32, so the tests place loads just below such a carry and just below the 64-bit wrap. A wrong carry out appears as a wrap pulse in the wrong cycle, or as a missing pulse, within a few cycles of a near-wrap load.

// File: rtl/systime_pkg.sv
package systime_pkg;

    localparam int TIME_W = 64;
    localparam int HALF_W = 32;
    localparam int PER_W  = 8;
    localparam int INC_W  = 24;
    localparam int ADDR_W = 2;
    localparam int RATE_W = PER_W + INC_W;

    // Rate word: step length in the upper byte, increment below it.
    typedef struct packed {
        logic [PER_W-1:0] period;
        logic [INC_W-1:0] inc;
    } rate_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_TIME_LO = 2'd0,
        REG_TIME_HI = 2'd1,
        REG_RATE    = 2'd2,
        REG_NONE    = 2'd3
    } reg_sel_e;

    function automatic logic step_done(input logic [PER_W-1:0] cnt,
                                       input logic [PER_W-1:0] period);
        return (period != '0) && (cnt == period - 1'b1);
    endfunction

    function automatic logic [TIME_W-1:0] widen_inc(input logic [INC_W-1:0] inc);
        return {{(TIME_W-INC_W){1'b0}}, inc};
    endfunction

endpackage

// File: rtl/systime_prescale.sv
module systime_prescale
    import systime_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  rate_t            rate_req,
    output logic             tick,
    output rate_t            rate_act
);

    logic [PER_W-1:0] cnt_q;
    rate_t            act_q;

    assign tick     = step_done(cnt_q, act_q.period);
    assign rate_act = act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            cnt_q <= '0;
        end else if (restart) begin
            act_q <= rate_req;
            cnt_q <= '0;
        end else if (act_q.period == '0) begin
            act_q <= rate_req;
            cnt_q <= '0;
        end else if (tick) begin
            act_q <= rate_req;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/systime_accum.sv
module systime_accum
    import systime_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    input  logic              tick,
    input  logic [INC_W-1:0]  inc,
    output logic [TIME_W-1:0] time_q,
    output logic              wrap_q
);

    logic [TIME_W:0] sum;

    assign sum = {1'b0, time_q} + {1'b0, widen_inc(inc)};

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= '0;
            wrap_q <= 1'b0;
        end else if (load) begin
            time_q <= load_val;
            wrap_q <= 1'b0;
        end else if (tick) begin
            time_q <= sum[TIME_W-1:0];
            wrap_q <= sum[TIME_W];
        end else begin
            wrap_q <= 1'b0;
        end
    end

endmodule

// File: rtl/systime_regs.sv
module systime_regs
    import systime_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    input  logic [TIME_W-1:0] time_q,
    output logic [HALF_W-1:0] bus_rdata,
    output rate_t             rate_q,
    output logic              load,
    output logic [TIME_W-1:0] load_val,
    output logic [HALF_W-1:0] hi_latch
);

    reg_sel_e          sel;
    logic [HALF_W-1:0] stage_q;
    logic [HALF_W-1:0] hi_q;

    assign sel      = reg_sel_e'(bus_addr);
    assign load     = bus_wr && (sel == REG_TIME_HI);
    assign load_val = {bus_wdata, stage_q};
    assign hi_latch = hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            hi_q    <= '0;
            rate_q  <= '0;
        end else begin
            if (bus_wr && sel == REG_TIME_LO) stage_q <= bus_wdata;
            if (bus_wr && sel == REG_RATE)    rate_q  <= rate_t'(bus_wdata);
            if (bus_rd && sel == REG_TIME_LO) hi_q    <= time_q[TIME_W-1:HALF_W];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                REG_TIME_LO: bus_rdata = time_q[HALF_W-1:0];
                REG_TIME_HI: bus_rdata = hi_q;
                REG_RATE:    bus_rdata = rate_q;
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/systime_counter.sv
module systime_counter
    import systime_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              wrap_pulse
);

    rate_t             rate_q;
    rate_t             rate_act;
    logic              tick;
    logic              load;
    logic [TIME_W-1:0] load_val;
    logic [TIME_W-1:0] time_q;
    logic [HALF_W-1:0] hi_latch;
    logic [PER_W-1:0]  act_period;

    assign act_period = rate_act.period;

    systime_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .time_q    (time_q),
        .bus_rdata (bus_rdata),
        .rate_q    (rate_q),
        .load      (load),
        .load_val  (load_val),
        .hi_latch  (hi_latch)
    );

    systime_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (load),
        .rate_req (rate_q),
        .tick     (tick),
        .rate_act (rate_act)
    );

    systime_accum u_acc (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .tick     (tick),
        .inc      (rate_act.inc),
        .time_q   (time_q),
        .wrap_q   (wrap_pulse)
    );

endmodule

// File: rtl/systime_counter_chk.sv
module systime_counter_chk
    import systime_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              load,
    input logic [TIME_W-1:0] load_val,
    input logic              tick,
    input logic [PER_W-1:0]  act_period,
    input logic [TIME_W-1:0] time_q,
    input logic [HALF_W-1:0] hi_latch,
    input logic              wrap_pulse
);

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> time_q == $past(load_val));

    p_stopped_r4: assert property (@(posedge clk) disable iff (rst)
        (act_period == '0 && !load) |=> $stable(time_q));

    p_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd0) |=> hi_latch == $past(time_q[TIME_W-1:HALF_W]));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(time_q));

    p_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        (act_period != '0 && !tick && !load) |=> $stable(act_period));

    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |-> time_q < $past(time_q));

    p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |=> !wrap_pulse);

endmodule

bind systime_counter systime_counter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .load       (load),
    .load_val   (load_val),
    .tick       (tick),
    .act_period (act_period),
    .time_q     (time_q),
    .hi_latch   (hi_latch),
    .wrap_pulse (wrap_pulse)
);

// File: tb/systime_counter_tb.sv
module systime_counter_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] RATE_96 = 32'h03FA0000;
    localparam logic [31:0] RATE_25 = 32'h01A00000;
    localparam logic [63:0] V96 = 64'd16384000;
    localparam logic [63:0] V25 = 64'd10485760;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wrap_pulse;

    int checks = 0;
    int fails  = 0;
    int wraps_seen = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    systime_counter u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wrap_pulse (wrap_pulse)
    );

    always @(negedge clk) if (!rst && wrap_pulse) wraps_seen++;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Every bus task starts and ends just after a falling edge and spans one rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_time(output logic [63:0] t);
        logic [31:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        t = {hi, lo};
    endtask

    task automatic load(input logic [63:0] t);
        wr(2'd0, t[31:0]);
        wr(2'd1, t[63:32]);
    endtask

    task automatic load_and_read(input logic [63:0] t, input int k, output logic [63:0] v);
        load(t);
        idle(k);
        read_time(v);
    endtask

    task automatic t_reset;
        logic [63:0] v;
        logic [31:0] r;
        check("R1 wrap low", {63'd0, wrap_pulse}, 64'd0);
        read_time(v);
        check("R1 time zero", v, 64'd0);
        rd(2'd2, r);
        check("R1 rate zero", {32'd0, r}, 64'd0);
        idle(5);
        read_time(v);
        check("R1 stopped", v, 64'd0);
    endtask

    task automatic t_rate_reg;
        logic [31:0] r;
        wr(2'd2, RATE_96);
        rd(2'd2, r);
        check("R2 readback", {32'd0, r}, {32'd0, RATE_96});
        rd(2'd3, r);
        check("R2 unused addr", {32'd0, r}, 64'd0);
    endtask

    task automatic t_rate96;
        logic [63:0] t, v;
        t = 64'h0000_0123_0000_0000;
        load_and_read(t, 2, v);
        check("R3 before first step", v, t);
        load_and_read(t, 3, v);
        check("R3 first step", v, t + V96);
        load_and_read(t, 30, v);
        check("R9 96MHz ten steps", v, t + 10 * V96);
        load_and_read(64'h0000_0042_1111_0000, 2, v);
        check("R10 restart on load", v, 64'h0000_0042_1111_0000);
    endtask

    task automatic t_rate25;
        logic [63:0] t, v;
        wr(2'd2, RATE_25);
        t = 64'h0000_0007_0000_0100;
        load_and_read(t, 20, v);
        check("R9 25MHz twenty steps", v, t + 20 * V25);
    endtask

    task automatic t_wrap25;
        logic [63:0] t, v;
        int w0;
        t = 64'hFFFF_FFFF_FFFF_FFFF - 2 * V25 + 64'd6;
        w0 = wraps_seen;
        load(t);
        check("R8 no pulse at load", {63'd0, wrap_pulse}, 64'd0);
        idle(1);
        check("R8 no pulse before wrap", {63'd0, wrap_pulse}, 64'd0);
        idle(1);
        check("R8 pulse at wrap", {63'd0, wrap_pulse}, 64'd1);
        idle(1);
        check("R8 pulse one cycle", {63'd0, wrap_pulse}, 64'd0);
        read_time(v);
        check("R8 wrapped value", v, 64'd5 + V25);
        check("R8 pulse count", 64'(wraps_seen - w0), 64'd1);
    endtask

    task automatic t_wrap96;
        logic [63:0] t, v;
        int w0;
        wr(2'd2, RATE_96);
        t = 64'hFFFF_FFFF_FFFF_FFFF - V96 + 64'd1 + 64'h40;
        w0 = wraps_seen;
        load_and_read(t, 3, v);
        check("R8 96MHz wrap value", v, 64'h40);
        check("R8 96MHz pulse count", 64'(wraps_seen - w0), 64'd1);
    endtask

    task automatic t_boundary;
        logic [63:0] t, v;
        wr(2'd2, 32'h03000010);
        t = 64'h0000_0010_0000_0000;
        load(t);
        wr(2'd2, 32'h01001000);
        idle(7);
        read_time(v);
        check("R7 old step completes", v, t + 64'h10 + 5 * 64'h1000);
    endtask

    task automatic t_stop;
        logic [63:0] a, b, t;
        wr(2'd2, 32'h01000100);
        wr(2'd2, 32'h00000100);
        idle(2);
        read_time(a);
        idle(10);
        read_time(b);
        check("R4 frozen after boundary", b, a);
        t = 64'h0000_0abc_0000_0def;
        load_and_read(t, 6, b);
        check("R4 zero step holds load", b, t);
    endtask

    task automatic t_latch;
        logic [31:0] lo, hi;
        logic [63:0] t;
        wr(2'd2, 32'h01100000);
        t = 64'h0000_0005_FFE0_0000;
        load(t);
        rd(2'd0, lo);
        check("R5 low at load", {32'd0, lo}, 64'hFFE0_0000);
        idle(5);
        rd(2'd1, hi);
        check("R5 high latched", {32'd0, hi}, 64'd5);
        rd(2'd0, lo);
        rd(2'd1, hi);
        check("R5 high relatched", {32'd0, hi}, 64'd6);
    endtask

    task automatic t_stage;
        logic [63:0] v;
        wr(2'd2, 32'h0);
        idle(3);
        load(64'h0000_0077_0000_0088);
        wr(2'd0, 32'hDEAD_BEEF);
        read_time(v);
        check("R6 low write staged only", v, 64'h0000_0077_0000_0088);
        wr(2'd1, 32'h0000_0099);
        read_time(v);
        check("R6 high write loads pair", v, 64'h0000_0099_DEAD_BEEF);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rate_reg();
        t_rate96();
        t_rate25();
        t_wrap25();
        t_wrap96();
        t_boundary();
        t_stop();
        t_latch();
        t_stage();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule